// File: doc/BRIEF.md
# Prioritized Route Lookup Unit

This unit owns a lookup table of 12-bit entries addressed by 12-bit indices. It takes work from two input streams. The command stream carries table writes and table reads. The packet stream carries packet words. A read returns the stored entry on a reply stream. A packet is routed by using its low 12 bits as a table index. The low bits of the entry it finds name which of several output streams receives the unchanged packet word.

A combinational scheduler fires at most one operation per cycle. A write beats a read, and a read beats a route. An operation is ready only when its input head is present and of the right kind, and its destination has space. Lookups run through a two-stage pipeline: a synchronous RAM read, then a result register. The effect is still as if each operation were atomic. A write waits until no lookup is in flight, and while it waits no new route is admitted. Packets pass through one in-order pipeline, so their order is kept.

Every data stream uses valid/ready. A beat transfers on a rising clock edge where both are high. A source holds valid and its data steady until the beat transfers. Input ready (`cmd_ready`, `pkt_ready`) is a combinational function of the input valid and the unit's state. The reply stream and each output stream is fed from an internal queue. Each of these queues holds its head steady while its ready is low.

Top module: `route_lookup_unit`

## Requirements
- R1: At most one operation fires per cycle. When more than one is ready, priority is table write, then table read, then route. A write and a packet presented together with an idle pipeline: the write fires first, and the packet is routed with the new value.
- R2: A command with `cmd_write`=1 stores the 12-bit `cmd_data` at the 12-bit `cmd_addr`. All 4096 addresses are distinct.
- R3: A command with `cmd_write`=0 places the entry stored at `cmd_addr` on `rsp_data`. Replies leave in the order their reads were accepted. The head reply and `rsp_valid` hold while `rsp_ready` is low.
- R4: A packet is delivered unchanged on output stream q, in bits [16q+15:16q] of `out_data`. Here q is bits [1:0] of the table entry at index `pkt_data[11:0]`. No other stream receives it.
- R5: A write is accepted only when no lookup is in flight. While a write is at the command head, `pkt_ready` is 0. A packet accepted before the write sees the old entry, and a packet accepted after it sees the new entry.
- R6: Packets sent to the same output stream leave it in the order they were accepted.
- R7: A read is not accepted while the reply queue cannot take its result. Meanwhile `cmd_ready` stays 0 and packets are still routed.
- R8: A packet is accepted only when every output queue has a free slot for it beyond the lookups already in flight. With output stream 2 stalled after four packets (queue depth 4), `pkt_ready` stays 0 for the fifth.
- R9: After reset, all output streams and the reply stream show valid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command stream valid |
| cmd_ready | output | 1 | Command accepted this cycle |
| cmd_write | input | 1 | 1 = table write, 0 = table read |
| cmd_addr | input | 12 | Table index for the command |
| cmd_data | input | 12 | Value to store on a write |
| pkt_valid | input | 1 | Packet stream valid |
| pkt_ready | output | 1 | Packet accepted this cycle |
| pkt_data | input | 16 | Packet word; bits [11:0] are the table index |
| rsp_valid | output | 1 | Reply stream valid |
| rsp_ready | input | 1 | Reply consumer ready |
| rsp_data | output | 12 | Entry returned by a read |
| out_valid | output | 4 | Per output stream valid |
| out_ready | input | 4 | Per output stream ready |
| out_data | output | 64 | Output words, stream q in bits [16q+15:16q] |

## Verification
The bench issues a write to an index while a packet for that same index is still in the pipeline, then queues a second packet behind the write. A design that let the second packet slip ahead of the write would route it with the stale entry. A design that stalled the first packet would route it with the new entry. The reply queue is filled with its consumer stalled, and a packet is sent during the blocked read. This catches a scheduler that lets a blocked read starve routes, or that accepts a read with nowhere to put its result. An output queue is also stalled full to show that admission stops. Once the queue is released, the backed-up packets must come out in order with none lost.

// File: rtl/rlu_pkg.sv
package rlu_pkg;
  // Kind of work carried by a lookup pipeline stage.
  typedef enum logic [1:0] {
    K_IDLE  = 2'd0,
    K_READ  = 2'd1,
    K_ROUTE = 2'd2
  } rlu_kind_e;
endpackage

// File: rtl/rlu_fifo.sv
module rlu_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  output logic          deq_valid,
  input  logic          deq_ready,
  output logic [W-1:0]  deq_data,
  output logic [CW-1:0] free
);
  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             pop;

  assign deq_valid = (count != '0);
  assign deq_data  = store[rd_ptr];
  assign pop       = deq_valid && deq_ready;
  assign free      = CW'(DEPTH) - count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8: the admission reservation must keep every queue from overflowing
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count != CW'(DEPTH)));
endmodule

// File: rtl/rlu_table.sv
module rlu_table #(
  parameter int AW = 12,
  parameter int DW = 12,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
    if (rd_en) rd_q <= cells[rd_addr];
  end

  // R1: the single table port never sees a write and a lookup together
  a_r1_single_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));
endmodule

// File: rtl/rlu_sched.sv
module rlu_sched (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_write,
  input  logic pkt_valid,
  input  logic pipe_busy,
  input  logic rsp_room,
  input  logic out_room,
  output logic fire_wr,
  output logic fire_rd,
  output logic fire_rt
);
  logic wr_head, rd_ok, rt_ok;

  always_comb begin
    wr_head = cmd_valid && cmd_write;
    rd_ok   = cmd_valid && !cmd_write && rsp_room;
    rt_ok   = pkt_valid && out_room && !wr_head;
    fire_wr = wr_head && !pipe_busy;
    fire_rd = !fire_wr && rd_ok;
    fire_rt = !fire_wr && !fire_rd && rt_ok;
  end

  // R1: one transaction per cycle
  a_r1_one_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fire_wr, fire_rd, fire_rt}));
endmodule

// File: rtl/route_lookup_unit.sv
module route_lookup_unit
  import rlu_pkg::*;
#(
  parameter int AW     = 12,
  parameter int DW     = 12,
  parameter int PKT_W  = 16,
  parameter int NQ     = 4,
  parameter int QDEPTH = 4,
  localparam int QSEL_W = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int CW     = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [DW-1:0]     cmd_data,
  input  logic              pkt_valid,
  output logic              pkt_ready,
  input  logic [PKT_W-1:0]  pkt_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_data,
  output logic [NQ-1:0]     out_valid,
  input  logic [NQ-1:0]     out_ready,
  output logic [NQ*PKT_W-1:0] out_data
);
  rlu_kind_e          s1_kind, s2_kind;
  logic [PKT_W-1:0]   s1_pkt, s2_pkt;
  logic [DW-1:0]      s2_val, tbl_q;
  logic               fire_wr, fire_rd, fire_rt;
  logic [CW-1:0]      inflight, rsp_free;
  logic [CW-1:0]      out_free [NQ];
  logic [NQ-1:0]      q_room;
  logic               rsp_room;

  always_comb begin
    inflight = CW'(s1_kind != K_IDLE) + CW'(s2_kind != K_IDLE);
    rsp_room = rsp_free > inflight;
  end

  rlu_sched u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .pkt_valid (pkt_valid),
    .pipe_busy (inflight != '0),
    .rsp_room  (rsp_room),
    .out_room  (&q_room),
    .fire_wr   (fire_wr),
    .fire_rd   (fire_rd),
    .fire_rt   (fire_rt)
  );

  assign cmd_ready = fire_wr || fire_rd;
  assign pkt_ready = fire_rt;

  rlu_table #(.AW(AW), .DW(DW)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fire_wr),
    .wr_addr (cmd_addr),
    .wr_data (cmd_data),
    .rd_en   (fire_rd || fire_rt),
    .rd_addr (fire_rd ? cmd_addr : pkt_data[AW-1:0]),
    .rd_q    (tbl_q)
  );

  // Stage 1 waits on the RAM read; stage 2 holds the looked-up entry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_kind <= K_IDLE;
      s2_kind <= K_IDLE;
    end else begin
      s1_kind <= fire_rd ? K_READ : (fire_rt ? K_ROUTE : K_IDLE);
      s2_kind <= s1_kind;
    end
  end

  always_ff @(posedge clk) begin
    s1_pkt <= pkt_data;
    s2_pkt <= s1_pkt;
    s2_val <= tbl_q;
  end

  rlu_fifo #(.W(DW), .DEPTH(QDEPTH)) u_rsp_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (s2_kind == K_READ),
    .din       (s2_val),
    .deq_valid (rsp_valid),
    .deq_ready (rsp_ready),
    .deq_data  (rsp_data),
    .free      (rsp_free)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_outq
    assign q_room[q] = out_free[q] > inflight;
    rlu_fifo #(.W(PKT_W), .DEPTH(QDEPTH)) u_out_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      ((s2_kind == K_ROUTE) && (s2_val[QSEL_W-1:0] == QSEL_W'(q))),
      .din       (s2_pkt),
      .deq_valid (out_valid[q]),
      .deq_ready (out_ready[q]),
      .deq_data  (out_data[q*PKT_W +: PKT_W]),
      .free      (out_free[q])
    );
  end

  // R5: a write lands only on an empty lookup pipeline
  a_r5_write_drained: assert property (@(posedge clk) disable iff (!rst_n)
    fire_wr |-> (s1_kind == K_IDLE && s2_kind == K_IDLE));
  // R5: no packet is admitted behind a waiting write
  a_r5_no_route_past_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write) |-> !pkt_ready);
  // R3: a stalled reply holds steady
  a_r3_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: tb/route_lookup_unit_tb.sv
`timescale 1ns/1ps
module route_lookup_unit_tb;
  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0, cmd_write = 0;
  logic [11:0] cmd_addr = 0, cmd_data = 0;
  logic        cmd_ready, pkt_ready, rsp_valid;
  logic        pkt_valid = 0, rsp_ready = 1;
  logic [15:0] pkt_data = 0;
  logic [11:0] rsp_data;
  logic [3:0]  out_valid, out_ready = 4'hF;
  logic [63:0] out_data;

  int n_chk = 0, n_fail = 0;
  logic [15:0] olog [4][64];
  int          ocnt [4];
  logic [11:0] rlog [64];
  int          rcnt = 0;

  route_lookup_unit u_dut (.*);

  always #2 clk = ~clk;

  initial for (int q = 0; q < 4; q++) ocnt[q] = 0;

  // Record every beat that transfers at the coming edge.
  always begin
    @(negedge clk); #1;
    if (rst_n) begin
      for (int q = 0; q < 4; q++)
        if (out_valid[q] && out_ready[q] && ocnt[q] < 64) begin
          olog[q][ocnt[q]] = out_data[q*16 +: 16];
          ocnt[q]++;
        end
      if (rsp_valid && rsp_ready && rcnt < 64) begin
        rlog[rcnt] = rsp_data;
        rcnt++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic wr, input logic [11:0] a, input logic [11:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_addr = a; cmd_data = d;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic send_pkt(input logic [15:0] d);
    @(negedge clk);
    pkt_valid = 1; pkt_data = d;
    #1;
    while (!pkt_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    pkt_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {index, entry}: entry bits [1:0] pick the output stream
  localparam logic [23:0] VEC [8] = '{
    {12'h000, 12'h001}, {12'hFFF, 12'h802}, {12'h123, 12'hABF}, {12'h7FE, 12'h000},
    {12'h400, 12'h555}, {12'h0AA, 12'hF02}, {12'h3C3, 12'h00F}, {12'h801, 12'h124}
  };

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int b0, b1, b2, b3, rb;
    logic rdy_seen;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 out_valid", {28'd0, out_valid}, 0);
    chk("R9 rsp_valid", {31'd0, rsp_valid}, 0);
    rst_n = 1;
    idle(2);
    chk("R9 out_valid after release", {28'd0, out_valid}, 0);

    // Table walk: write, read back, route a packet per vector.
    for (int i = 0; i < 8; i++) begin
      logic [11:0] a, v;
      int q, base, rbase;
      a = VEC[i][23:12]; v = VEC[i][11:0]; q = int'(v[1:0]);
      send_cmd(1'b1, a, v);
      rbase = rcnt;
      send_cmd(1'b0, a, 12'h0);
      idle(6);
      chk("R2/R3 read count", rcnt - rbase, 1);
      chk("R2/R3 read value", {20'd0, rlog[rbase]}, {20'd0, v});
      base = ocnt[q];
      b0 = ocnt[0] + ocnt[1] + ocnt[2] + ocnt[3];
      send_pkt({4'(i), a});
      idle(6);
      chk("R4 stream", ocnt[q] - base, 1);
      chk("R4 only one stream", ocnt[0] + ocnt[1] + ocnt[2] + ocnt[3] - b0, 1);
      chk("R4 data", {16'd0, olog[q][base]}, {16'd0, 4'(i), a});
    end

    // R5: write queued behind an in-flight lookup of the same index.
    send_cmd(1'b1, 12'h055, 12'h100);
    b0 = ocnt[0]; b3 = ocnt[3];
    rdy_seen = 1'b1;
    fork
      send_pkt(16'hA055);
      begin @(negedge clk); send_cmd(1'b1, 12'h055, 12'h103); end
      begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        pkt_valid = 1; pkt_data = 16'hB055; #1;
        rdy_seen = pkt_ready;
        while (!pkt_ready) begin @(negedge clk); #1; end
        @(negedge clk); pkt_valid = 0;
      end
    join
    idle(8);
    chk("R5 pkt_ready low behind write", {31'd0, rdy_seen}, 0);
    chk("R5 older packet old entry", ocnt[0] - b0, 1);
    chk("R5 older packet data", {16'd0, olog[0][b0]}, 32'hA055);
    chk("R5 newer packet new entry", ocnt[3] - b3, 1);
    chk("R5 newer packet data", {16'd0, olog[3][b3]}, 32'hB055);

    // R1: write and packet offered together, write wins.
    send_cmd(1'b1, 12'h066, 12'h000);
    idle(4);
    b1 = ocnt[1];
    fork
      send_cmd(1'b1, 12'h066, 12'h001);
      send_pkt(16'hC066);
    join
    idle(8);
    chk("R1 write before route", ocnt[1] - b1, 1);
    chk("R1 data", {16'd0, olog[1][b1]}, 32'hC066);

    // R6 / R8: stall stream 2, fill it, fifth packet blocked.
    send_cmd(1'b1, 12'h0AB, 12'h0F2);
    idle(4);
    b2 = ocnt[2];
    out_ready[2] = 0;
    for (int k = 0; k < 4; k++) send_pkt(16'h10AB + 16'(k) * 16'h1000);
    fork
      send_pkt(16'h50AB);
      begin
        idle(10); #1;
        chk("R8 pkt_ready low when full", {31'd0, pkt_ready}, 0);
        chk("R8 nothing leaves stalled stream", ocnt[2] - b2, 0);
        @(negedge clk);
        out_ready[2] = 1;
      end
    join
    idle(10);
    chk("R8 all five delivered", ocnt[2] - b2, 5);
    for (int k = 0; k < 5; k++)
      chk("R6 order", {16'd0, olog[2][b2 + k]}, {16'd0, 16'h10AB + 16'(k) * 16'h1000});

    // R7 / R3: reply queue stalled, routes continue.
    rsp_ready = 0;
    rb = rcnt;
    for (int k = 0; k < 4; k++) send_cmd(1'b0, VEC[k][23:12], 12'h0);
    b0 = ocnt[1];
    fork
      send_cmd(1'b0, VEC[4][23:12], 12'h0);
      begin
        send_pkt(16'hD000);
        idle(4); #1;
        chk("R7 cmd_ready low when reply full", {31'd0, cmd_ready}, 0);
        chk("R7 route proceeds", ocnt[1] - b0, 1);
        chk("R3 reply held", {31'd0, rsp_valid}, 1);
        chk("R3 head steady", {20'd0, rsp_data}, {20'd0, VEC[0][11:0]});
        @(negedge clk);
        rsp_ready = 1;
      end
    join
    idle(10);
    chk("R7 five replies", rcnt - rb, 5);
    for (int k = 0; k < 5; k++)
      chk("R3 reply order", {20'd0, rlog[rb + k]}, {20'd0, VEC[k][11:0]});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule